// File: doc/BRIEF.md
# Command Sequence Legality Checker

This block sits next to a register-programming command interpreter and judges every decoded command before it runs. Each command carries a class, a target offset, a payload length in bytes, a wrap length, a block-select mask, lookup-table fields and the number of bytes left in the command buffer. The checker decides whether the command may be accepted. It can refuse a command for four reasons: the command comes at the wrong point in the sequence, one of its parameters is out of range, it would not fit in the buffer, or its block mask names a combination of groups that cannot share a selection.

The checker keeps a small state that records which command classes may come next. It also records whether a block selection and a register write have both been accepted since the last buffer clear. A launch request is answered with a flag that says whether the buffer holds enough to be worth sending. The first refusal after a buffer clear is kept as a 3-bit reason code until the next clear. Refused commands leave the sequencing state unchanged.

Top module: `cmdseq_guard`

## Requirements
- R1: After reset or a `buf_clr` cycle, `err_code` is 0 and `launch_ok` is 0. Only a block-select command (class 0) may follow. Any other class is refused with code 2 (ordering).
- R2: After an accepted block-select, only write classes are allowed: 1 single write, 2 masked modify, 3 auto-increment, 4 indexed, 5 wrap block write, 6 lookup-table write. A second block-select is refused with code 2.
- R3: After an accepted class 1, 2, 3, 4 or 6 command, either another write or a new block-select is accepted.
- R4: After an accepted class 5 (wrap) command, only write classes are accepted. A block-select is refused with code 2.
- R5: A block-select with mask zero is refused with code 4. The mask has video bits [3:0], DMA bits [7:4], post-processing bits [11:8] and a global bit [12]. If bits from more than one of the three groups are set, the command is refused with code 4. If the global bit is set together with any group bit, the command is refused with code 4.
- R6: A write whose offset exceeds 0xFFFFF, or whose offset has bits [1:0] not zero, is refused with code 5.
- R7: A write whose payload byte count is not a multiple of 4, or exceeds 16383 words, is refused with code 6.
- R8: A wrap write with a wrap length outside 2..15 is refused with code 7. A lookup-table write is refused with code 7 if any of these hold: table index ≥ 2, block index ≥ 5, or transfer size other than 16 or 32.
- R9: A command needs header bytes plus payload bytes. The header is 8 bytes for classes 0, 1, 3, 4 and 5, 12 bytes for class 2, and 20 bytes for class 6 (including trailing padding). A block-select carries no payload. If the bytes needed exceed `space_left`, the command is refused with code 3. This check has priority over the other parameter checks.
- R10: A `launch_req` is answered one cycle later. `launch_ok` is 1 only if a block-select and a write have both been accepted since the last clear.
- R11: Each valid command produces exactly one of `cmd_accept` or `cmd_error` on the next cycle. A refused command does not change which classes are allowed next.
- R12: Class 7 is refused with code 1. `err_code` keeps the first refusal's code until the next clear, and later refusals do not overwrite it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_clr | input | 1 | Buffer clear; restarts sequencing and clears the reason code |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_class | input | 3 | Command class (0 select … 6 lookup-table, 7 reserved) |
| cmd_offset | input | 32 | Target register byte offset |
| cmd_bytes | input | 18 | Payload length in bytes |
| cmd_wrap | input | 5 | Wrap length for class 5 |
| cmd_mask | input | 13 | Block-select mask |
| lut_table | input | 2 | Lookup-table index |
| lut_block | input | 4 | Lookup-table block index |
| lut_trans | input | 8 | Lookup-table transfer size |
| space_left | input | 18 | Bytes remaining in the command buffer |
| launch_req | input | 1 | Request for a launch verdict |
| cmd_accept | output | 1 | Previous-cycle command accepted |
| cmd_error | output | 1 | Previous-cycle command refused |
| err_code | output | 3 | Held code of the first refusal since clear |
| launch_ok | output | 1 | Verdict for the previous-cycle launch request |

## Verification
Every result is registered once. The accept/error pulse and the reason code appear on the first rising edge after the command is presented. A launch verdict appears on the first edge after the request, and it reflects the commands accepted on earlier edges. The bench drives each stimulus on a falling edge, waits for the next rising edge and samples a nanosecond later. Every expectation is therefore read in the cycle where that single register stage has just updated. The sticky code is followed across sequences of several commands, so later refusals are seen not to overwrite it.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

  typedef enum logic [2:0] {
    CL_SEL    = 3'd0,
    CL_SINGLE = 3'd1,
    CL_MODIFY = 3'd2,
    CL_INC    = 3'd3,
    CL_IDX    = 3'd4,
    CL_WRAP   = 3'd5,
    CL_LUT    = 3'd6,
    CL_RSVD   = 3'd7
  } cmd_class_e;

  typedef enum logic [2:0] {
    EC_NONE   = 3'd0,
    EC_CLASS  = 3'd1,
    EC_ORDER  = 3'd2,
    EC_SPACE  = 3'd3,
    EC_MASK   = 3'd4,
    EC_OFFSET = 3'd5,
    EC_SIZE   = 3'd6,
    EC_PARAM  = 3'd7
  } err_code_e;

  typedef enum logic [1:0] {
    AS_NEED_SEL  = 2'd0,
    AS_WR_ONLY   = 2'd1,
    AS_WR_OR_SEL = 2'd2
  } allow_e;

  // header words occupied by each class (lookup-table includes 3 pad words)
  function automatic logic [2:0] hdr_words(cmd_class_e c);
    case (c)
      CL_MODIFY: hdr_words = 3'd3;
      CL_LUT:    hdr_words = 3'd5;
      default:   hdr_words = 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/cmdseq_mask_chk.sv
module cmdseq_mask_chk #(
  parameter int VID_N = 4,
  parameter int DMA_N = 4,
  parameter int PP_N  = 4,
  localparam int MASK_W = VID_N + DMA_N + PP_N + 1
) (
  input  logic [MASK_W-1:0] mask,
  output logic              bad
);
  localparam int NGRP = 3;

  logic [NGRP-1:0] hit;
  logic            top_hit;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = (g == 0) ? 0 : (g == 1) ? VID_N : VID_N + DMA_N;
    localparam int W  = (g == 0) ? VID_N : (g == 1) ? DMA_N : PP_N;
    assign hit[g] = |mask[LO +: W];
  end

  assign top_hit = mask[MASK_W-1];

  always_comb begin
    bad = 1'b0;
    if (mask == '0)
      bad = 1'b1;
    else if ((hit & (hit - NGRP'(1))) != '0)
      bad = 1'b1;
    else if (top_hit && (hit != '0))
      bad = 1'b1;
  end
endmodule

// File: rtl/cmdseq_param_chk.sv
module cmdseq_param_chk
  import cmdseq_pkg::*;
#(
  parameter int OFF_W      = 32,
  parameter int MAX_OFF    = 'hFFFFF,
  parameter int PAY_W      = 18,
  parameter int MAX_WORDS  = 16383,
  parameter int WRAP_W     = 5,
  parameter int WRAP_MIN   = 2,
  parameter int WRAP_MAX   = 15,
  parameter int TBL_W      = 2,
  parameter int LUT_TABLES = 2,
  parameter int BSEL_W     = 4,
  parameter int LUT_BLOCKS = 5,
  parameter int TSZ_W      = 8,
  parameter int TSZ_A      = 16,
  parameter int TSZ_B      = 32,
  parameter int SPACE_W    = 18
) (
  input  cmd_class_e         cls,
  input  logic [OFF_W-1:0]   offset,
  input  logic [PAY_W-1:0]   pay_bytes,
  input  logic [WRAP_W-1:0]  wrap,
  input  logic [TBL_W-1:0]   tbl,
  input  logic [BSEL_W-1:0]  bsel,
  input  logic [TSZ_W-1:0]   tsz,
  input  logic [SPACE_W-1:0] space,
  input  logic               mask_bad,
  output err_code_e          code
);
  localparam int NEED_W = ((PAY_W > SPACE_W) ? PAY_W : SPACE_W) + 2;

  logic              is_sel;
  logic [NEED_W-1:0] need;
  logic              space_bad, size_bad, off_bad, wrap_bad, lut_bad;

  assign is_sel = (cls == CL_SEL);

  always_comb begin
    need = (NEED_W'(hdr_words(cls)) << 2) + (is_sel ? '0 : NEED_W'(pay_bytes));
  end

  assign space_bad = need > NEED_W'(space);
  assign size_bad  = (pay_bytes[1:0] != 2'b00) ||
                     (PAY_W'(pay_bytes >> 2) > PAY_W'(MAX_WORDS));
  assign off_bad   = (offset > OFF_W'(MAX_OFF)) || (offset[1:0] != 2'b00);
  assign wrap_bad  = (wrap < WRAP_W'(WRAP_MIN)) || (wrap > WRAP_W'(WRAP_MAX));
  assign lut_bad   = (tbl >= TBL_W'(LUT_TABLES)) || (bsel >= BSEL_W'(LUT_BLOCKS)) ||
                     ((tsz != TSZ_W'(TSZ_A)) && (tsz != TSZ_W'(TSZ_B)));

  always_comb begin
    code = EC_NONE;
    if (space_bad)
      code = EC_SPACE;
    else if (is_sel) begin
      if (mask_bad) code = EC_MASK;
    end else if (size_bad)
      code = EC_SIZE;
    else if (off_bad)
      code = EC_OFFSET;
    else if (cls == CL_WRAP && wrap_bad)
      code = EC_PARAM;
    else if (cls == CL_LUT && lut_bad)
      code = EC_PARAM;
  end
endmodule

// File: rtl/cmdseq_order.sv
module cmdseq_order
  import cmdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       cmd_valid,
  input  cmd_class_e cls,
  input  err_code_e  chk_code,
  input  logic       launch_req,
  output logic       acc_o,
  output logic       err_o,
  output err_code_e  code_o,
  output logic       launch_ok_o
);
  allow_e    st;
  logic      sel_done, wr_done;
  logic      is_sel, order_ok, good, bad;
  err_code_e fault;

  assign is_sel   = (cls == CL_SEL);
  assign order_ok = is_sel ? (st != AS_WR_ONLY) : (st != AS_NEED_SEL);

  always_comb begin
    if (cls == CL_RSVD)   fault = EC_CLASS;
    else if (!order_ok)   fault = EC_ORDER;
    else                  fault = chk_code;
  end

  assign good = cmd_valid && (fault == EC_NONE);
  assign bad  = cmd_valid && (fault != EC_NONE);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st          <= AS_NEED_SEL;
      sel_done    <= 1'b0;
      wr_done     <= 1'b0;
      acc_o       <= 1'b0;
      err_o       <= 1'b0;
      code_o      <= EC_NONE;
      launch_ok_o <= 1'b0;
    end else begin
      acc_o       <= good;
      err_o       <= bad;
      launch_ok_o <= launch_req && sel_done && wr_done;
      if (bad && code_o == EC_NONE)
        code_o <= fault;
      if (good) begin
        if (is_sel) begin
          st       <= AS_WR_ONLY;
          sel_done <= 1'b1;
        end else begin
          st      <= (cls == CL_WRAP) ? AS_WR_ONLY : AS_WR_OR_SEL;
          wr_done <= 1'b1;
        end
      end
    end
  end

  // R1: right after a clear only a block-select may pass
  p_first_sel_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !clr && st == AS_NEED_SEL && !is_sel) |=> (err_o && !acc_o));

  // R4: block-select directly after a wrap write is refused
  p_wrap_no_sel_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !clr && st == AS_WR_ONLY && is_sel) |=> err_o);

  // R11: a valid command yields exactly one verdict
  p_one_verdict_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !clr) |=> (acc_o ^ err_o));

  // R11: no verdict without a command
  p_no_verdict_r11: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid) |=> (!acc_o && !err_o));

  // R12: a held code stays put until a clear
  p_code_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (code_o != EC_NONE && !clr) |=> $stable(code_o));

  // R10: a launch verdict only answers a request
  p_launch_req_r10: assert property (@(posedge clk) disable iff (rst)
    launch_ok_o |-> $past(launch_req));
endmodule

// File: rtl/cmdseq_guard.sv
module cmdseq_guard
  import cmdseq_pkg::*;
#(
  parameter int VID_N      = 4,
  parameter int DMA_N      = 4,
  parameter int PP_N       = 4,
  parameter int OFF_W      = 32,
  parameter int MAX_OFF    = 'hFFFFF,
  parameter int PAY_W      = 18,
  parameter int MAX_WORDS  = 16383,
  parameter int WRAP_W     = 5,
  parameter int WRAP_MIN   = 2,
  parameter int WRAP_MAX   = 15,
  parameter int TBL_W      = 2,
  parameter int LUT_TABLES = 2,
  parameter int BSEL_W     = 4,
  parameter int LUT_BLOCKS = 5,
  parameter int TSZ_W      = 8,
  parameter int TSZ_A      = 16,
  parameter int TSZ_B      = 32,
  parameter int SPACE_W    = 18,
  localparam int MASK_W    = VID_N + DMA_N + PP_N + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               buf_clr,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_class,
  input  logic [OFF_W-1:0]   cmd_offset,
  input  logic [PAY_W-1:0]   cmd_bytes,
  input  logic [WRAP_W-1:0]  cmd_wrap,
  input  logic [MASK_W-1:0]  cmd_mask,
  input  logic [TBL_W-1:0]   lut_table,
  input  logic [BSEL_W-1:0]  lut_block,
  input  logic [TSZ_W-1:0]   lut_trans,
  input  logic [SPACE_W-1:0] space_left,
  input  logic               launch_req,
  output logic               cmd_accept,
  output logic               cmd_error,
  output logic [2:0]         err_code,
  output logic               launch_ok
);
  cmd_class_e cls;
  logic       mask_bad;
  err_code_e  chk_code;
  err_code_e  held_code;

  assign cls = cmd_class_e'(cmd_class);

  cmdseq_mask_chk #(
    .VID_N(VID_N), .DMA_N(DMA_N), .PP_N(PP_N)
  ) u_mask (
    .mask (cmd_mask),
    .bad  (mask_bad)
  );

  cmdseq_param_chk #(
    .OFF_W(OFF_W), .MAX_OFF(MAX_OFF), .PAY_W(PAY_W), .MAX_WORDS(MAX_WORDS),
    .WRAP_W(WRAP_W), .WRAP_MIN(WRAP_MIN), .WRAP_MAX(WRAP_MAX),
    .TBL_W(TBL_W), .LUT_TABLES(LUT_TABLES), .BSEL_W(BSEL_W),
    .LUT_BLOCKS(LUT_BLOCKS), .TSZ_W(TSZ_W), .TSZ_A(TSZ_A), .TSZ_B(TSZ_B),
    .SPACE_W(SPACE_W)
  ) u_param (
    .cls       (cls),
    .offset    (cmd_offset),
    .pay_bytes (cmd_bytes),
    .wrap      (cmd_wrap),
    .tbl       (lut_table),
    .bsel      (lut_block),
    .tsz       (lut_trans),
    .space     (space_left),
    .mask_bad  (mask_bad),
    .code      (chk_code)
  );

  cmdseq_order u_order (
    .clk         (clk),
    .rst         (rst),
    .clr         (buf_clr),
    .cmd_valid   (cmd_valid),
    .cls         (cls),
    .chk_code    (chk_code),
    .launch_req  (launch_req),
    .acc_o       (cmd_accept),
    .err_o       (cmd_error),
    .code_o      (held_code),
    .launch_ok_o (launch_ok)
  );

  assign err_code = held_code;

  // R5: an empty select mask is always refused
  p_mask_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !buf_clr && cls == CL_SEL && cmd_mask == '0) |=> cmd_error);

  // R1: a clear leaves no code and no launch verdict
  p_clear_r1: assert property (@(posedge clk) disable iff (rst)
    buf_clr |=> (err_code == 3'd0 && !launch_ok && !cmd_accept));
endmodule

// File: tb/cmdseq_guard_bench.sv
module cmdseq_guard_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        buf_clr;
  logic        cmd_valid;
  logic [2:0]  cmd_class;
  logic [31:0] cmd_offset;
  logic [17:0] cmd_bytes;
  logic [4:0]  cmd_wrap;
  logic [12:0] cmd_mask;
  logic [1:0]  lut_table;
  logic [3:0]  lut_block;
  logic [7:0]  lut_trans;
  logic [17:0] space_left;
  logic        launch_req;
  logic        cmd_accept, cmd_error, launch_ok;
  logic [2:0]  err_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cmdseq_guard u_cmdseq_guard (
    .clk(clk), .rst(rst), .buf_clr(buf_clr), .cmd_valid(cmd_valid),
    .cmd_class(cmd_class), .cmd_offset(cmd_offset), .cmd_bytes(cmd_bytes),
    .cmd_wrap(cmd_wrap), .cmd_mask(cmd_mask), .lut_table(lut_table),
    .lut_block(lut_block), .lut_trans(lut_trans), .space_left(space_left),
    .launch_req(launch_req), .cmd_accept(cmd_accept), .cmd_error(cmd_error),
    .err_code(err_code), .launch_ok(launch_ok)
  );

  task automatic idle_inputs();
    buf_clr = 0; cmd_valid = 0; cmd_class = 0; cmd_offset = 0; cmd_bytes = 4;
    cmd_wrap = 4; cmd_mask = 13'h1; lut_table = 0; lut_block = 0;
    lut_trans = 8'h10; space_left = 18'd1024; launch_req = 0;
  endtask

  task automatic issue(input logic [2:0] cls, input logic [31:0] off = 0,
                       input logic [17:0] pay = 4, input logic [4:0] wrp = 4,
                       input logic [12:0] msk = 13'h1, input logic [1:0] tbl = 0,
                       input logic [3:0] bsl = 0, input logic [7:0] tsz = 8'h10,
                       input logic [17:0] spc = 18'd1024);
    @(negedge clk);
    cmd_valid = 1; cmd_class = cls; cmd_offset = off; cmd_bytes = pay;
    cmd_wrap = wrp; cmd_mask = msk; lut_table = tbl; lut_block = bsl;
    lut_trans = tsz; space_left = spc;
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic expect_v(input string tag, input bit e_acc, input bit e_err,
                          input logic [2:0] e_code);
    n_checks++;
    if (cmd_accept !== e_acc || cmd_error !== e_err || err_code !== e_code) begin
      n_fail++;
      $display("FAIL %s: acc/err/code = %0b/%0b/%0d expected %0b/%0b/%0d",
               tag, cmd_accept, cmd_error, err_code, e_acc, e_err, e_code);
    end
  endtask

  task automatic ok(input string tag, input logic [2:0] e_code);
    expect_v(tag, 1'b1, 1'b0, e_code);
  endtask

  task automatic ng(input string tag, input logic [2:0] e_code);
    expect_v(tag, 1'b0, 1'b1, e_code);
  endtask

  task automatic clear();
    @(negedge clk); buf_clr = 1;
    @(negedge clk); buf_clr = 0;
  endtask

  task automatic ask_launch(input string tag, input bit e_ok);
    @(negedge clk); launch_req = 1;
    @(posedge clk); #1; launch_req = 0;
    n_checks++;
    if (launch_ok !== e_ok) begin
      n_fail++;
      $display("FAIL %s: launch_ok = %0b expected %0b", tag, launch_ok, e_ok);
    end
  endtask

  task automatic t_reset();
    expect_v("R1 reset state", 0, 0, 0);
    n_checks++;
    if (launch_ok !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset launch_ok: %0b expected 0", launch_ok);
    end
  endtask

  task automatic t_first_select();
    clear();
    issue(1); ng("R1 write before select", 2);
    issue(0); ok("R12 code held after accept", 2);
    clear();
    @(posedge clk); #1; expect_v("R1 clear drops code", 0, 0, 0);
  endtask

  task automatic t_select_then_writes();
    clear();
    issue(0); ok("R2 select", 0);
    issue(0); ng("R2 select after select", 2);
    clear();
    issue(0); issue(1); ok("R3 single", 0);
    issue(0); ok("R3 select after single", 0);
    issue(2); ok("R3 modify", 0);
    issue(3); ok("R3 inc", 0);
    issue(4); ok("R3 indexed", 0);
    issue(6); ok("R3 lut", 0);
    issue(0); ok("R3 select after lut", 0);
  endtask

  task automatic t_wrap_order();
    clear();
    issue(0); issue(5); ok("R4 wrap write", 0);
    issue(0); ng("R4 select after wrap", 2);
    issue(1); ok("R11 refused cmd kept state", 2);
  endtask

  task automatic t_mask();
    clear(); issue(0, .msk(13'h0000)); ng("R5 zero mask", 4);
    clear(); issue(0, .msk(13'h0011)); ng("R5 video+dma", 4);
    clear(); issue(0, .msk(13'h1100)); ng("R5 global+post", 4);
    clear(); issue(0, .msk(13'h000F)); ok("R5 all video", 0);
    clear(); issue(0, .msk(13'h1000)); ok("R5 global alone", 0);
    clear(); issue(0, .msk(13'h0F00)); ok("R5 post group", 0);
  endtask

  task automatic t_offset();
    clear(); issue(0);
    issue(1, .off(32'h000FFFFC)); ok("R6 top offset", 0);
    issue(1, .off(32'h00100000)); ng("R6 offset too big", 5);
    clear(); issue(0);
    issue(3, .off(32'h00000002)); ng("R6 unaligned offset", 5);
  endtask

  task automatic t_size();
    clear(); issue(0);
    issue(3, .pay(18'd65532), .spc(18'h3FFFF)); ok("R7 max words", 0);
    issue(3, .pay(18'd65536), .spc(18'h3FFFF)); ng("R7 too many words", 6);
    clear(); issue(0);
    issue(4, .pay(18'd6)); ng("R7 unaligned size", 6);
  endtask

  task automatic t_params();
    clear(); issue(0); issue(5, .wrp(5'd1));  ng("R8 wrap 1", 7);
    clear(); issue(0); issue(5, .wrp(5'd16)); ng("R8 wrap 16", 7);
    clear(); issue(0); issue(5, .wrp(5'd2));  ok("R8 wrap 2", 0);
    issue(5, .wrp(5'd15)); ok("R8 wrap 15", 0);
    clear(); issue(0); issue(6, .tbl(2'd2));  ng("R8 lut table", 7);
    clear(); issue(0); issue(6, .bsl(4'd5));  ng("R8 lut block", 7);
    clear(); issue(0); issue(6, .tsz(8'h30)); ng("R8 lut trans", 7);
    clear(); issue(0); issue(6, .bsl(4'd4), .tsz(8'h20), .tbl(2'd1)); ok("R8 lut edges", 0);
  endtask

  task automatic t_space();
    clear();
    issue(0, .spc(18'd7)); ng("R9 select no room", 3);
    issue(0, .spc(18'd8)); ok("R9 select exact", 3);
    issue(2, .pay(18'd4), .spc(18'd16)); ok("R9 modify exact", 3);
    issue(2, .pay(18'd4), .spc(18'd15)); ng("R9 modify short", 3);
    clear(); issue(0);
    issue(6, .pay(18'd8), .spc(18'd28)); ok("R9 lut exact", 0);
    issue(6, .pay(18'd8), .spc(18'd27)); ng("R9 lut short", 3);
    clear(); issue(0);
    issue(1, .off(32'h3), .pay(18'd4), .spc(18'd11)); ng("R9 space before offset", 3);
  endtask

  task automatic t_launch();
    clear();
    ask_launch("R10 empty buffer", 0);
    issue(0);
    ask_launch("R10 select only", 0);
    issue(1);
    ask_launch("R10 select and write", 1);
    clear();
    ask_launch("R1 launch after clear", 0);
  endtask

  task automatic t_reserved();
    clear(); issue(0);
    issue(7); ng("R12 reserved class", 1);
    issue(1, .off(32'h2)); ng("R12 later fault keeps code", 1);
    @(posedge clk); #1; expect_v("R11 idle cycle", 0, 0, 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    #1; rst = 0;
    @(posedge clk); #1;
    t_reset();
    t_first_select();
    t_select_then_writes();
    t_wrap_order();
    t_mask();
    t_offset();
    t_size();
    t_params();
    t_space();
    t_launch();
    t_reserved();
    finished = 1;
    summary();
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
    end
  end
endmodule